// File: doc/BRIEF.md
# Register-plus-immediate operand ALU

This block is the execute stage of a RISC-style machine whose instructions are 64 bits wide. Each instruction brings an 8-bit opcode, a destination register selector, two register operands and a full 32-bit immediate. For every arithmetic, logic, shift and compare opcode, the second operand is not chosen between a register and an immediate. It is always the wrapped sum of the second register and the immediate. So the same opcode covers both the register-register and the register-immediate forms.

Conditional branch opcodes compare the two register operands directly, with no immediate added. They report whether the branch is taken, along with the target, which is the program counter plus the immediate. Any opcode outside these two sets is flagged as illegal and has no side effects. The register file, fetch, memory and program-counter sequencing belong to neighbouring blocks.

All outputs are registered. The values presented at one rising clock edge appear on the outputs just after that edge. A synchronous active-high reset clears every output.

Top module: `nvx_exec_alu`

## Requirements
- R1: For every ALU opcode the effective second operand is (B + imm) mod 2^32, formed before the operation. add (0x40) gives A + eff, sub (0x41) gives A - eff and mul (0x4A) gives the low 32 bits of A * eff, all wrapping mod 2^32.
- R2: The logic opcodes are or (0x47), and (0x48) and xor (0x49). Each gives the bitwise operation of A and eff.
- R3: The shift opcodes are sll (0x44), logical right shift (0x45) and arithmetic right shift (0x46). Each shifts A by eff[4:0]. The arithmetic shift fills with A[31].
- R4: slt (0x42) compares A with eff as signed values and sltu (0x43) compares them as unsigned values. Each returns 1 when A is less than eff and 0 otherwise.
- R5: div (0x4B) returns the unsigned quotient A / eff. When eff is 0 it returns 0xFFFFFFFF and flags nothing.
- R6: For an ALU opcode, wr_en is 1 when the destination selector is nonzero and 0 when it is zero. The result port still carries the computed value in both cases. br_taken and illegal are 0.
- R7: The branch opcodes compare A with B directly: beq 0x11 (equal), bne 0x12 (not equal), blt 0x13 (signed less), bge 0x14 (signed greater or equal), bltu 0x15 (unsigned less) and bgeu 0x16 (unsigned greater or equal). For these opcodes br_taken is the outcome of the comparison and br_target is pc + imm mod 2^32. wr_en, result and illegal are 0.
- R8: For any other opcode, illegal is 1 and wr_en, br_taken, result and br_target are all 0.
- R9: While rst is high at a rising edge, every output is 0 after that edge.
- R10: The outputs change only at a rising edge, and they reflect the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 8 | Opcode |
| rd_sel | input | 5 | Destination register selector |
| opa | input | 32 | First register operand A |
| opb | input | 32 | Second register operand B |
| imm | input | 32 | Immediate |
| pc | input | 32 | Program counter of the instruction |
| result | output | 32 | ALU result |
| wr_en | output | 1 | Register write enable |
| br_taken | output | 1 | Conditional branch taken |
| br_target | output | 32 | Branch target pc + imm |
| illegal | output | 1 | Opcode not handled by this unit |

## Verification
Random operands seldom produce an effective operand of exactly zero, because B + imm must wrap to zero. They also seldom produce shift sums whose upper bits must be ignored, or register pairs that are equal. The stimulus therefore builds these cases on purpose. Some directed vectors pick imm as the two's complement of B, and others pick a sum above 31. In the random stream, one vector in four copies A into B, and some force the destination to register zero, so that the divide-by-zero rule, the shift mask, the equality branches and write suppression are all reached.

// File: rtl/nvx_alu_pkg.sv
package nvx_alu_pkg;
  localparam int OPW = 8;
  localparam logic [OPW-1:0] OP_ADD  = 8'h40;
  localparam logic [OPW-1:0] OP_SUB  = 8'h41;
  localparam logic [OPW-1:0] OP_SLT  = 8'h42;
  localparam logic [OPW-1:0] OP_SLTU = 8'h43;
  localparam logic [OPW-1:0] OP_SLL  = 8'h44;
  localparam logic [OPW-1:0] OP_SRL  = 8'h45;
  localparam logic [OPW-1:0] OP_SRA  = 8'h46;
  localparam logic [OPW-1:0] OP_OR   = 8'h47;
  localparam logic [OPW-1:0] OP_AND  = 8'h48;
  localparam logic [OPW-1:0] OP_XOR  = 8'h49;
  localparam logic [OPW-1:0] OP_MUL  = 8'h4A;
  localparam logic [OPW-1:0] OP_DIV  = 8'h4B;
  localparam logic [OPW-1:0] OP_BEQ  = 8'h11;
  localparam logic [OPW-1:0] OP_BNE  = 8'h12;
  localparam logic [OPW-1:0] OP_BLT  = 8'h13;
  localparam logic [OPW-1:0] OP_BGE  = 8'h14;
  localparam logic [OPW-1:0] OP_BLTU = 8'h15;
  localparam logic [OPW-1:0] OP_BGEU = 8'h16;

  typedef enum logic [1:0] {
    CLS_BAD = 2'd0,
    CLS_ALU = 2'd1,
    CLS_BR  = 2'd2
  } op_class_e;
endpackage

// File: rtl/nvx_op_classify.sv
module nvx_op_classify
  import nvx_alu_pkg::*;
(
  input  logic [OPW-1:0] op,
  output op_class_e      cls
);
  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB, OP_SLT, OP_SLTU, OP_SLL, OP_SRL,
      OP_SRA, OP_OR, OP_AND, OP_XOR, OP_MUL, OP_DIV: cls = CLS_ALU;
      OP_BEQ, OP_BNE, OP_BLT, OP_BGE, OP_BLTU, OP_BGEU: cls = CLS_BR;
      default: cls = CLS_BAD;
    endcase
  end
endmodule

// File: rtl/nvx_alu_core.sv
module nvx_alu_core
  import nvx_alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [OPW-1:0]  op,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [XLEN-1:0] imm,
  output logic [XLEN-1:0] res
);
  localparam int SHW = $clog2(XLEN);

  logic [XLEN-1:0] eff;
  logic [SHW-1:0]  shamt;
  logic [XLEN-1:0] prod;
  logic [XLEN-1:0] quot;

  assign eff   = opb + imm;
  assign shamt = eff[SHW-1:0];
  assign prod  = opa * eff;
  assign quot  = (eff == '0) ? '1 : opa / eff;

  always_comb begin
    unique case (op)
      OP_ADD:  res = opa + eff;
      OP_SUB:  res = opa - eff;
      OP_SLT:  res = {{(XLEN-1){1'b0}}, $signed(opa) < $signed(eff)};
      OP_SLTU: res = {{(XLEN-1){1'b0}}, opa < eff};
      OP_SLL:  res = opa << shamt;
      OP_SRL:  res = opa >> shamt;
      OP_SRA:  res = $unsigned($signed(opa) >>> shamt);
      OP_OR:   res = opa | eff;
      OP_AND:  res = opa & eff;
      OP_XOR:  res = opa ^ eff;
      OP_MUL:  res = prod;
      OP_DIV:  res = quot;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/nvx_br_eval.sv
module nvx_br_eval
  import nvx_alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [OPW-1:0]  op,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            taken
);
  logic eq, lt_s, lt_u;

  assign eq   = (opa == opb);
  assign lt_s = $signed(opa) < $signed(opb);
  assign lt_u = opa < opb;

  always_comb begin
    unique case (op)
      OP_BEQ:  taken = eq;
      OP_BNE:  taken = !eq;
      OP_BLT:  taken = lt_s;
      OP_BGE:  taken = !lt_s;
      OP_BLTU: taken = lt_u;
      OP_BGEU: taken = !lt_u;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/nvx_exec_alu.sv
module nvx_exec_alu
  import nvx_alu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RSW  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [7:0]      op,
  input  logic [RSW-1:0]  rd_sel,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [XLEN-1:0] imm,
  input  logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] result,
  output logic            wr_en,
  output logic            br_taken,
  output logic [XLEN-1:0] br_target,
  output logic            illegal
);
  op_class_e       cls;
  logic [XLEN-1:0] core_res;
  logic            cmp_taken;

  nvx_op_classify u_cls (.op(op), .cls(cls));

  nvx_alu_core #(.XLEN(XLEN)) u_core (
    .op(op), .opa(opa), .opb(opb), .imm(imm), .res(core_res)
  );

  nvx_br_eval #(.XLEN(XLEN)) u_br (
    .op(op), .opa(opa), .opb(opb), .taken(cmp_taken)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      wr_en     <= 1'b0;
      br_taken  <= 1'b0;
      br_target <= '0;
      illegal   <= 1'b0;
    end else begin
      result    <= (cls == CLS_ALU) ? core_res : '0;
      wr_en     <= (cls == CLS_ALU) && (rd_sel != '0);
      br_taken  <= (cls == CLS_BR) && cmp_taken;
      br_target <= (cls == CLS_BR) ? pc + imm : '0;
      illegal   <= (cls == CLS_BAD);
    end
  end

  // R8: an illegal opcode leaves no side effect
  a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!wr_en && !br_taken && result == '0));

  // R6: register zero is never written
  a_r6_zero_dest: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_sel) == '0) |-> !wr_en);

  // R5: divide by a zero effective operand yields all ones
  a_r5_div_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_DIV && $past(opb + imm) == '0)
      |-> (result == '1));

  // R6/R7/R8: at most one of write, branch, illegal
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_en, br_taken, illegal}));

  // R7: branch target follows pc + imm
  a_r7_target: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cls) == CLS_BR) |-> (br_target == $past(pc + imm)));

  // R9: outputs cleared after a reset edge
  a_r9_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!wr_en && !br_taken && !illegal && result == '0));
endmodule

// File: tb/test_nvx_exec_alu.sv
module test_nvx_exec_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  op = 8'h00;
  logic [4:0]  rd_sel = 5'd0;
  logic [31:0] opa = '0, opb = '0, imm = '0, pc = '0;
  logic [31:0] result, br_target;
  logic        wr_en, br_taken, illegal;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] e_res, e_tgt;
  logic        e_wr, e_br, e_ill;

  always #5 clk = ~clk;

  nvx_exec_alu i_nvx_exec_alu (
    .clk(clk), .rst(rst), .op(op), .rd_sel(rd_sel), .opa(opa), .opb(opb),
    .imm(imm), .pc(pc), .result(result), .wr_en(wr_en), .br_taken(br_taken),
    .br_target(br_target), .illegal(illegal)
  );

  function automatic bit is_alu(input logic [7:0] o);
    return (o >= 8'h40) && (o <= 8'h4B);
  endfunction

  function automatic bit is_br(input logic [7:0] o);
    return (o >= 8'h11) && (o <= 8'h16);
  endfunction

  function automatic logic [31:0] ref_alu(input logic [7:0] o,
      input logic [31:0] a, input logic [31:0] b, input logic [31:0] i);
    logic [31:0] e;
    logic [63:0] p;
    int sh;
    e  = b + i;
    sh = int'(e & 32'h1F);
    p  = {32'd0, a} * {32'd0, e};
    case (o)
      8'h40: return a + e;
      8'h41: return a + (~e + 32'd1);
      8'h42: return (a[31] != e[31]) ? {31'd0, a[31]} : {31'd0, a < e};
      8'h43: return {31'd0, a < e};
      8'h44: return a << sh;
      8'h45: return a >> sh;
      8'h46: begin
        logic [63:0] w;
        w = {{32{a[31]}}, a} >> sh;
        return w[31:0];
      end
      8'h47: return a | e;
      8'h48: return a & e;
      8'h49: return a ^ e;
      8'h4A: return p[31:0];
      8'h4B: return (e == 0) ? 32'hFFFF_FFFF : a / e;
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit ref_br(input logic [7:0] o,
      input logic [31:0] a, input logic [31:0] b);
    logic [31:0] fa, fb;
    fa = a ^ 32'h8000_0000;
    fb = b ^ 32'h8000_0000;
    case (o)
      8'h11: return a == b;
      8'h12: return a != b;
      8'h13: return fa < fb;
      8'h14: return fa >= fb;
      8'h15: return a < b;
      8'h16: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] o);
    if (o == 8'h40 || o == 8'h41 || o == 8'h4A) return "R1";
    if (o >= 8'h47 && o <= 8'h49) return "R2";
    if (o >= 8'h44 && o <= 8'h46) return "R3";
    if (o == 8'h42 || o == 8'h43) return "R4";
    if (o == 8'h4B) return "R5";
    if (is_br(o)) return "R7";
    return "R8";
  endfunction

  task automatic compute_exp();
    e_res = is_alu(op) ? ref_alu(op, opa, opb, imm) : 32'd0;
    e_wr  = is_alu(op) && (rd_sel != 0);
    e_br  = is_br(op) && ref_br(op, opa, opb);
    e_tgt = is_br(op) ? pc + imm : 32'd0;
    e_ill = !is_alu(op) && !is_br(op);
  endtask

  task automatic compare(input string tag);
    n_chk++;
    if (result !== e_res || wr_en !== e_wr || br_taken !== e_br ||
        br_target !== e_tgt || illegal !== e_ill) begin
      n_bad++;
      $display("FAIL %s op=%h a=%h b=%h imm=%h rd=%0d: got res=%h wr=%b br=%b tgt=%h ill=%b exp res=%h wr=%b br=%b tgt=%h ill=%b",
               tag, op, opa, opb, imm, rd_sel, result, wr_en, br_taken,
               br_target, illegal, e_res, e_wr, e_br, e_tgt, e_ill);
    end
  endtask

  task automatic apply(input logic [7:0] o, input logic [4:0] r,
      input logic [31:0] a, input logic [31:0] b, input logic [31:0] i,
      input logic [31:0] p, input string tag);
    @(negedge clk);
    op = o; rd_sel = r; opa = a; opb = b; imm = i; pc = p;
    compute_exp();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] alu_ops [12];
    logic [7:0] br_ops [6];
    void'($urandom(32'd20240611));
    for (int k = 0; k < 12; k++) alu_ops[k] = 8'h40 + 8'(k);
    for (int k = 0; k < 6; k++) br_ops[k] = 8'h11 + 8'(k);

    // R9: reset clears outputs even with a live ALU op on the inputs
    op = 8'h40; rd_sel = 5'd3; opa = 32'd7; opb = 32'd9;
    repeat (3) @(negedge clk);
    e_res = 0; e_wr = 0; e_br = 0; e_tgt = 0; e_ill = 0;
    compare("R9");
    @(negedge clk);
    rst = 1'b0;
    op = 8'h00;

    // R1: operand sum wraps, then the subtraction wraps
    apply(8'h40, 5'd1, 32'd5, 32'hFFFF_FFFF, 32'd3, 0, "R1");
    apply(8'h41, 5'd1, 32'd1, 32'd1, 32'd1, 0, "R1");
    apply(8'h4A, 5'd2, 32'h8000_0001, 32'd1, 32'd2, 0, "R1");
    // R2
    apply(8'h48, 5'd4, 32'hF0F0_F0F0, 32'h0F00_0000, 32'h00FF_FFFF, 0, "R2");
    // R3: shift sum 0x23 uses only 3; arithmetic fill
    apply(8'h44, 5'd5, 32'h0000_0001, 32'h20, 32'h3, 0, "R3");
    apply(8'h46, 5'd5, 32'h8000_0000, 32'd4, 32'hFFFF_FFFF, 0, "R3");
    apply(8'h45, 5'd5, 32'h8000_0000, 32'd31, 32'd0, 0, "R3");
    // R4: signed vs unsigned disagree
    apply(8'h42, 5'd6, 32'hFFFF_FFFF, 32'd0, 32'd1, 0, "R4");
    apply(8'h43, 5'd6, 32'hFFFF_FFFF, 32'd0, 32'd1, 0, "R4");
    // R5: effective zero via imm = -B, then an ordinary unsigned quotient
    apply(8'h4B, 5'd7, 32'd100, 32'd25, 32'hFFFF_FFE7, 0, "R5");
    apply(8'h4B, 5'd7, 32'hFFFF_FFFE, 32'd1, 32'd1, 0, "R5");
    // R6: register zero suppressed, result still shown
    apply(8'h40, 5'd0, 32'd10, 32'd20, 32'd30, 0, "R6");
    // R7: equal operands, signed/unsigned split, target wrap
    apply(8'h11, 5'd9, 32'h1234, 32'h1234, 32'd16, 32'hFFFF_FFF8, "R7");
    apply(8'h13, 5'd9, 32'hFFFF_FFFF, 32'd1, 32'd8, 32'd64, "R7");
    apply(8'h15, 5'd9, 32'hFFFF_FFFF, 32'd1, 32'd8, 32'd64, "R7");
    // R8: nop-like and halt-like codes
    apply(8'h01, 5'd3, 32'd1, 32'd2, 32'd3, 32'd8, "R8");
    apply(8'hFF, 5'd3, 32'd1, 32'd2, 32'd3, 32'd8, "R8");

    // R10: outputs hold until the edge, then follow
    @(negedge clk);
    op = 8'h40; rd_sel = 5'd1; opa = 32'd1; opb = 32'd1; imm = 32'd1; pc = 0;
    #1;
    compare("R10");
    compute_exp();
    @(negedge clk);
    compare("R10");

    for (int n = 0; n < 3000; n++) begin
      logic [7:0]  o;
      logic [31:0] a, b, i;
      logic [4:0]  r;
      int pick;
      pick = int'($urandom % 4);
      if (pick < 2) o = alu_ops[$urandom % 12];
      else if (pick == 2) o = br_ops[$urandom % 6];
      else o = 8'($urandom);
      a = ($urandom % 3 == 0) ? 32'($urandom % 64) : $urandom;
      b = ($urandom % 4 == 0) ? a : $urandom;
      i = ($urandom % 5 == 0) ? (~b + 32'd1) : (($urandom % 2 == 0) ? 32'($urandom % 40) : $urandom);
      r = ($urandom % 8 == 0) ? 5'd0 : 5'($urandom);
      apply(o, r, a, b, i, $urandom, (r == 0 && is_alu(o)) ? "R6" : tag_of(o));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule